// File: doc/BRIEF.md
# Reloadable Interval Timer with Timeout Pin

This block is a 16-bit down-counting interval timer for an 8-bit memory-mapped peripheral. Software reaches four byte-wide registers through a 2-bit sub-address: the running count, split into low and high bytes, and a 16-bit reload value, also split into low and high bytes. A write to the count-high byte starts a period. The count then drops by one on every cycle in which the clock-enable tick is high. The timeout comes on the tick that finds the count at zero, so a reload value of N gives a period of N+1 ticks.

A mode input selects the behaviour at timeout. In single-shot mode the timer raises its flag once and then keeps counting down from 0xFFFF without raising it again. In repeating mode it reloads the count from the stored reload value and raises the flag on every timeout. When the pin-drive input is set, the timeout pin follows the timer. In repeating mode it gives a square wave. In single-shot mode it gives one low pulse that runs from the start until the first timeout. The flag output feeds a shared interrupt flag register at bit position 6. That register, its enable logic and the port pin multiplexing sit outside this block.

Top module: `interval_timer`

## Requirements
- R1: After reset the flag is 0, the timeout pin is 1, and the count reads 0 and stays 0 under ticks until a start.
- R2: Writing sub-address 0 or 2 stores the byte as the reload low byte and leaves the count unchanged. Reads of sub-address 2 and 3 return the reload low and high bytes.
- R3: Writing sub-address 1 stores the byte as the reload high byte, loads the count with {written byte, reload low byte}, starts counting and clears the flag.
- R4: The count decrements by one only on cycles with tick high. Reads of sub-address 0 and 1 return the count's low and high bytes.
- R5: A timeout occurs on a tick that finds the count at 0. In repeating mode (mode=1) the count reloads from the reload value and the flag sets at every timeout, so each period is reload+1 ticks.
- R6: In single-shot mode (mode=0) the flag sets only at the first timeout after a start, and the count wraps to 0xFFFF and keeps counting.
- R7: Reading sub-address 0 or pulsing the flag-clear input clears the flag, but a timeout in the same cycle leaves it set.
- R8: Writing sub-address 3 changes only the reload high byte. A running count continues undisturbed, and the next reload uses the new value.
- R9: With pin drive enabled, a start drives the pin low. Repeating mode then inverts the pin at each timeout, while single-shot mode returns it high at the first timeout. With pin drive disabled, the pin stays 1.
- R10: A count-high write in the same cycle as a timeout takes precedence: the count loads the new value and the flag stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Count enable, one decrement per high cycle |
| regAddr | input | 2 | Sub-address: 0 count low, 1 count high, 2 reload low, 3 reload high |
| wrEn | input | 1 | Register write strobe |
| rdEn | input | 1 | Register read strobe |
| wrData | input | 8 | Write data |
| rdData | output | 8 | Read data for regAddr (combinational) |
| freeRun | input | 1 | Mode: 0 single-shot, 1 repeating |
| outEnable | input | 1 | Drive the timeout pin from the timer |
| flagClr | input | 1 | Clears the flag |
| irqFlag | output | 1 | Timeout flag (bit 6 of the shared flag register) |
| timerOut | output | 1 | Timeout pin |

## Verification
Two pairs of events can land in the same cycle. In the first pair, a timeout meets a flag clear, either from the flag-clear pulse or from a read of the count low byte. In the second pair, a timeout meets a count-high write. The bench steps the count to zero and then asserts the tick in the same cycle as the clear or the write. The expected result is that the flag stays set in the first case. In the second case the flag stays clear, and the count reads back the newly written value instead of a reload.

// File: rtl/itimer_pkg.sv
package itimer_pkg;
  localparam logic [1:0] SEL_CNT_LO = 2'd0;
  localparam logic [1:0] SEL_CNT_HI = 2'd1;
  localparam logic [1:0] SEL_LAT_LO = 2'd2;
  localparam logic [1:0] SEL_LAT_HI = 2'd3;

  typedef struct packed {
    logic loadLatLo;   // store reload low byte
    logic loadLatHi;   // store reload high byte only
    logic startCount;  // count-high write: latch high + load count
    logic countStep;   // count this cycle
    logic reload;      // take reload value instead of decrementing
  } dpStrobes_t;
endpackage

// File: rtl/itimer_ctrl.sv
module itimer_ctrl
  import itimer_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic [1:0] regAddr,
  input  logic       wrEn,
  input  logic       rdEn,
  input  logic       freeRun,
  input  logic       outEnable,
  input  logic       flagClr,
  input  logic       cntZero,
  output dpStrobes_t strobes,
  output logic       irqFlag,
  output logic       timerOut,
  output logic       timeout
);
  logic running;
  logic armed;
  logic pinLevel;
  logic wrCntHi;
  logic timeoutHit;
  logic clrReq;

  assign wrCntHi    = wrEn && (regAddr == SEL_CNT_HI);
  assign timeoutHit = strobes.countStep && cntZero;
  assign timeout    = timeoutHit && (freeRun || armed);
  assign clrReq     = flagClr || (rdEn && (regAddr == SEL_CNT_LO));

  always_comb begin
    strobes            = '0;
    strobes.loadLatLo  = wrEn && ((regAddr == SEL_CNT_LO) || (regAddr == SEL_LAT_LO));
    strobes.loadLatHi  = wrEn && (regAddr == SEL_LAT_HI);
    strobes.startCount = wrCntHi;
    strobes.countStep  = tick && running && !wrCntHi;
    strobes.reload     = timeoutHit && freeRun;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      running <= 1'b0;
      armed   <= 1'b0;
    end else if (wrCntHi) begin
      running <= 1'b1;
      armed   <= 1'b1;
    end else if (timeoutHit) begin
      armed   <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             irqFlag <= 1'b0;
    else if (wrCntHi)       irqFlag <= 1'b0;
    else if (timeout)       irqFlag <= 1'b1;
    else if (clrReq)        irqFlag <= 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             pinLevel <= 1'b1;
    else if (wrCntHi)       pinLevel <= 1'b0;
    else if (timeoutHit) begin
      if (freeRun)          pinLevel <= ~pinLevel;
      else if (armed)       pinLevel <= 1'b1;
    end
  end

  assign timerOut = outEnable ? pinLevel : 1'b1;
endmodule

// File: rtl/itimer_datapath.sv
module itimer_datapath
  import itimer_pkg::*;
#(
  parameter int BYTE_W = 8,
  localparam int CNT_W = 2 * BYTE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  dpStrobes_t        strobes,
  input  logic [1:0]        regAddr,
  input  logic [BYTE_W-1:0] wrData,
  output logic [BYTE_W-1:0] rdData,
  output logic              cntZero,
  output logic [CNT_W-1:0]  cntValue,
  output logic [CNT_W-1:0]  latchValue
);
  logic [BYTE_W-1:0] latchLo;
  logic [BYTE_W-1:0] latchHi;
  logic [CNT_W-1:0]  counter;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      latchLo <= '0;
      latchHi <= '0;
    end else begin
      if (strobes.loadLatLo)                      latchLo <= wrData;
      if (strobes.loadLatHi || strobes.startCount) latchHi <= wrData;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  counter <= '0;
    else if (strobes.startCount) counter <= {wrData, latchLo};
    else if (strobes.countStep)  counter <= strobes.reload ? {latchHi, latchLo} : counter - 1'b1;
  end

  always_comb begin
    unique case (regAddr)
      SEL_CNT_LO: rdData = counter[BYTE_W-1:0];
      SEL_CNT_HI: rdData = counter[CNT_W-1:BYTE_W];
      SEL_LAT_LO: rdData = latchLo;
      default:    rdData = latchHi;
    endcase
  end

  assign cntZero    = (counter == '0);
  assign cntValue   = counter;
  assign latchValue = {latchHi, latchLo};
endmodule

// File: rtl/interval_timer.sv
module interval_timer
  import itimer_pkg::*;
#(
  parameter int BYTE_W = 8,
  localparam int CNT_W = 2 * BYTE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic [1:0]        regAddr,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [BYTE_W-1:0] wrData,
  output logic [BYTE_W-1:0] rdData,
  input  logic              freeRun,
  input  logic              outEnable,
  input  logic              flagClr,
  output logic              irqFlag,
  output logic              timerOut
);
  dpStrobes_t       strobes;
  logic             cntZero;
  logic             timeout;
  logic [CNT_W-1:0] cntValue;
  logic [CNT_W-1:0] latchValue;

  itimer_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .tick(tick), .regAddr(regAddr),
    .wrEn(wrEn), .rdEn(rdEn), .freeRun(freeRun), .outEnable(outEnable),
    .flagClr(flagClr), .cntZero(cntZero), .strobes(strobes),
    .irqFlag(irqFlag), .timerOut(timerOut), .timeout(timeout)
  );

  itimer_datapath #(.BYTE_W(BYTE_W)) u_dp (
    .clk(clk), .rst_n(rst_n), .strobes(strobes), .regAddr(regAddr),
    .wrData(wrData), .rdData(rdData), .cntZero(cntZero),
    .cntValue(cntValue), .latchValue(latchValue)
  );
endmodule

// File: rtl/interval_timer_chk.sv
module interval_timer_chk #(
  parameter int BYTE_W = 8,
  localparam int CNT_W = 2 * BYTE_W
) (
  input logic              clk,
  input logic              rst_n,
  input logic              tick,
  input logic [1:0]        regAddr,
  input logic              wrEn,
  input logic [BYTE_W-1:0] wrData,
  input logic              freeRun,
  input logic              outEnable,
  input logic              irqFlag,
  input logic              timerOut,
  input logic              timeout,
  input logic [CNT_W-1:0]  cntValue,
  input logic [CNT_W-1:0]  latchValue
);
  a_r1_reset_idle: assert property (@(posedge clk) $rose(rst_n) |-> (!irqFlag && timerOut));

  a_r3_start_load: assert property (@(posedge clk) disable iff (!rst_n)
    (wrEn && regAddr == 2'd1) |=>
      (cntValue == {$past(wrData), $past(latchValue[BYTE_W-1:0])}) && !irqFlag);

  a_r4_hold_without_tick: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !(wrEn && regAddr == 2'd1)) |=> $stable(cntValue));

  a_r5_reload_value: assert property (@(posedge clk) disable iff (!rst_n)
    (timeout && freeRun) |=> (cntValue == $past(latchValue)));

  a_r7_timeout_sets_flag: assert property (@(posedge clk) disable iff (!rst_n)
    timeout |=> irqFlag);

  a_r9_pin_idle_high: assert property (@(posedge clk) disable iff (!rst_n)
    !outEnable |-> timerOut);
endmodule

bind interval_timer interval_timer_chk #(.BYTE_W(BYTE_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .tick(tick), .regAddr(regAddr), .wrEn(wrEn),
  .wrData(wrData), .freeRun(freeRun), .outEnable(outEnable),
  .irqFlag(irqFlag), .timerOut(timerOut), .timeout(timeout),
  .cntValue(cntValue), .latchValue(latchValue)
);

// File: tb/sim_interval_timer.sv
`timescale 1ns/1ps
module sim_interval_timer;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b0;
  logic [1:0] regAddr = 2'd0;
  logic       wrEn = 1'b0;
  logic       rdEn = 1'b0;
  logic [7:0] wrData = 8'd0;
  logic [7:0] rdData;
  logic       freeRun = 1'b0;
  logic       outEnable = 1'b1;
  logic       flagClr = 1'b0;
  logic       irqFlag;
  logic       timerOut;

  int checks = 0;
  int failures = 0;
  logic [7:0] rdVal;
  bit done = 0;

  always #2 clk = ~clk;

  interval_timer u0 (
    .clk(clk), .rst_n(rst_n), .tick(tick), .regAddr(regAddr), .wrEn(wrEn),
    .rdEn(rdEn), .wrData(wrData), .rdData(rdData), .freeRun(freeRun),
    .outEnable(outEnable), .flagClr(flagClr), .irqFlag(irqFlag), .timerOut(timerOut)
  );

  task automatic chkv(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic wrReg(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); regAddr = a; wrData = d; wrEn = 1'b1;
    @(negedge clk); wrEn = 1'b0;
  endtask

  task automatic rdReg(input logic [1:0] a);
    @(negedge clk); regAddr = a; rdEn = 1'b1; #1 rdVal = rdData;
    @(negedge clk); rdEn = 1'b0;
  endtask

  task automatic doTick();
    @(negedge clk); tick = 1'b1;
    @(negedge clk); tick = 1'b0;
  endtask

  task automatic pulseClr();
    @(negedge clk); flagClr = 1'b1;
    @(negedge clk); flagClr = 1'b0;
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    #(4 * 200000);
    failures++;
    $display("FAIL watchdog actual=timeout expected=finish");
    finishRun();
  end

  initial begin
    int k;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chkv("R1 flag", irqFlag, 0);
    chkv("R1 pin", timerOut, 1);
    repeat (4) doTick();
    rdReg(0); chkv("R1 count lo", rdVal, 0);
    rdReg(1); chkv("R1 count hi", rdVal, 0);
    chkv("R1 flag after ticks", irqFlag, 0);

    // R2 / R8 register access without start
    wrReg(0, 8'hA5); rdReg(2); chkv("R2 lat lo via 0", rdVal, 8'hA5);
    wrReg(2, 8'h3C); rdReg(2); chkv("R2 lat lo via 2", rdVal, 8'h3C);
    rdReg(0); chkv("R2 count untouched", rdVal, 0);
    wrReg(3, 8'h12); rdReg(3); chkv("R8 lat hi", rdVal, 8'h12);
    rdReg(1); chkv("R8 count hi untouched", rdVal, 0);

    // R5 R6 R9 sweep over modes and short periods
    for (int m = 0; m < 2; m++) begin
      for (int L = 0; L < 7; L++) begin
        freeRun = m[0];
        wrReg(0, 8'(L)); wrReg(1, 8'h00);
        chkv("R3 flag cleared", irqFlag, 0);
        chkv("R9 pin low at start", timerOut, 0);
        k = 0;
        while (!irqFlag && k < 20) begin
          rdReg(0); chkv("R4 count", rdVal, L - k);
          doTick(); k++;
        end
        chkv("R5 period", k, L + 1);
        chkv("R9 pin after timeout", timerOut, 1);
        rdReg(0); chkv(m ? "R5 reload" : "R6 wrap lo", rdVal, m ? L : 8'hFF);
        chkv("R7 read clears", irqFlag, 0);
        if (m == 1) begin
          k = 0;
          while (!irqFlag && k < 20) begin doTick(); k++; end
          chkv("R5 second period", k, L + 1);
          chkv("R9 toggle back", timerOut, 0);
          pulseClr(); chkv("R7 flagClr", irqFlag, 0);
        end else begin
          rdReg(1); chkv("R6 wrap hi", rdVal, 8'hFF);
          repeat (10) doTick();
          chkv("R6 single flag", irqFlag, 0);
          chkv("R9 pin stays high", timerOut, 1);
        end
      end
    end

    // R4 no count without tick
    freeRun = 1'b1;
    wrReg(0, 8'h05); wrReg(1, 8'h00);
    repeat (5) @(negedge clk);
    rdReg(0); chkv("R4 idle hold", rdVal, 5);
    doTick(); doTick();
    rdReg(0); chkv("R4 two ticks", rdVal, 3);

    // R5 borrow across bytes: 0x0100 -> 257 ticks
    wrReg(0, 8'h00); wrReg(1, 8'h01);
    k = 0;
    while (!irqFlag && k < 400) begin doTick(); k++; end
    chkv("R5 long period", k, 257);
    pulseClr();

    // R8 latch high write does not disturb count
    wrReg(0, 8'h10); wrReg(1, 8'h00);
    repeat (3) doTick();
    wrReg(3, 8'h00); wrReg(2, 8'h05);
    rdReg(0); chkv("R8 count kept lo", rdVal, 8'h0D);
    rdReg(1); chkv("R8 count kept hi", rdVal, 0);
    k = 0;
    while (!irqFlag && k < 40) begin doTick(); k++; end
    chkv("R8 remaining period", k, 14);
    rdReg(0); chkv("R8 new reload", rdVal, 5);

    // R7 timeout and flagClr in the same cycle
    wrReg(0, 8'h02); wrReg(1, 8'h00);
    doTick(); doTick();
    @(negedge clk); tick = 1'b1; flagClr = 1'b1;
    @(negedge clk); tick = 1'b0; flagClr = 1'b0;
    chkv("R7 set wins over clear", irqFlag, 1);
    pulseClr();
    doTick(); doTick();
    @(negedge clk); tick = 1'b1; rdEn = 1'b1; regAddr = 2'd0;
    @(negedge clk); tick = 1'b0; rdEn = 1'b0;
    chkv("R7 set wins over read", irqFlag, 1);
    pulseClr(); chkv("R7 cleared", irqFlag, 0);

    // R10 start write in the timeout cycle
    doTick(); doTick();
    @(negedge clk); tick = 1'b1; wrEn = 1'b1; regAddr = 2'd1; wrData = 8'h01;
    @(negedge clk); tick = 1'b0; wrEn = 1'b0;
    chkv("R10 no flag", irqFlag, 0);
    chkv("R10 pin low", timerOut, 0);
    rdReg(0); chkv("R10 count lo", rdVal, 2);
    rdReg(1); chkv("R10 count hi", rdVal, 1);

    // R9 pin drive disabled
    outEnable = 1'b0;
    wrReg(0, 8'h01); wrReg(1, 8'h00);
    for (int i = 0; i < 5; i++) begin
      doTick(); chkv("R9 disabled pin", timerOut, 1);
    end
    outEnable = 1'b1;

    finishRun();
  end
endmodule